// File: doc/BRIEF.md
# Omega Self-Routing Switch Fabric

This block is an N-port multistage interconnect built from log2(N) columns of 2x2 switching elements. A perfect-shuffle wiring feeds every column: lane j moves to lane j rotated left by one bit. Each port may present one word per cycle. A word has a valid flag, a destination port number and a payload. The fabric has no central routing table. Each element steers a word by one destination bit: the first column uses the most significant bit, and each later column uses the next lower bit. After the last column, every surviving word sits on the output port whose index equals its destination.

Each column's outputs are registered, so a set of words (a wave) crosses the fabric in log2(N) cycles, and a new wave may enter every cycle. Two valid words may meet in one element and ask for the same element output. In that case the word on the element's upper input proceeds and the other is discarded. The source port of a discarded word is marked, and the mark travels with its wave. Each output carries its word's destination, so a receiver can confirm the delivery.

Top module: `omega_fabric`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises with idle inputs, every out_valid_o and blocked_o bit is 0, whatever the inputs.
- R2: A wave presented at clock edge t appears on the outputs right after edge t+log2(N)-1, which is log2(N) registered stages. Before then the outputs show nothing of it.
- R3: A valid word that meets no contender leaves on the output port whose index equals its destination, with payload and destination unchanged. Input port i's destination sits in in_dest_i[i*AW +: AW], and its payload sits in in_data_i[i*DATA_W +: DATA_W]. Outputs use the same packing.
- R4: In column s the element compares destination bit log2(N)-1-s with the word's current source bit. Equal bits pass straight; different bits cross, and a destination bit of 1 selects the lower element output. If two valid words in one element need the same output, the word on the upper input wins and the other is discarded. The upper input is the one whose source bit for that column is 0.
- R5: blocked_o[i] is 1 in the same cycle as the outputs of input i's wave if input i's word was discarded in any column. Otherwise it is 0.
- R6: Invalid inputs produce no output word, never defeat a valid word and never raise a blocked_o bit, whatever their destination field holds.
- R7: A new wave is accepted on every clock edge. Waves in flight never alter one another's routing, outcome or blocked flags.
- R8: Each valid input word is accounted for exactly once: it is either delivered on one output or flagged in blocked_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Per-port word valid |
| in_dest_i | input | N_PORTS*AW | Per-port destination index, packed |
| in_data_i | input | N_PORTS*DATA_W | Per-port payload, packed |
| out_valid_o | output | N_PORTS | Per-port delivered word valid |
| out_dest_o | output | N_PORTS*AW | Destination carried with each delivered word |
| out_data_o | output | N_PORTS*DATA_W | Delivered payload |
| blocked_o | output | N_PORTS | Per-source flag: that input's word was discarded |

## Verification
Every cycle, the column assertions check four properties. A registered word sits on a lane whose low bits match the destination bits consumed so far. Valid words plus blocked marks are conserved from one column to the next. Blocked marks never clear inside a wave. An idle column stays idle. Other behaviours show only in the bench's scenarios: the exact output port and payload for a given permutation, which contender wins a conflict in each column, alignment of blocked_o with its wave, the latency count, and independence of back-to-back waves.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // rotate an index of 'bits' width left by one: perfect shuffle
  function automatic int shuffle_idx(input int idx, input int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int AW      = 3,
  parameter int DW      = 16,
  parameter int SEL_BIT = 2
) (
  input  logic [1:0]         v_i,
  input  logic [1:0][AW-1:0] dest_i,
  input  logic [1:0][AW-1:0] src_i,
  input  logic [1:0][DW-1:0] data_i,
  output logic [1:0]         v_o,
  output logic [1:0][AW-1:0] dest_o,
  output logic [1:0][AW-1:0] src_o,
  output logic [1:0][DW-1:0] data_o,
  output logic               lose_o
);
  logic [1:0] want;

  assign want[0] = dest_i[0][SEL_BIT];
  assign want[1] = dest_i[1][SEL_BIT];
  // port 0 = upper input, has priority
  assign lose_o  = v_i[0] & v_i[1] & (want[0] == want[1]);

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      v_o[p]    = 1'b0;
      dest_o[p] = dest_i[0];
      src_o[p]  = src_i[0];
      data_o[p] = data_i[0];
      if (v_i[0] && want[0] == 1'(p)) begin
        v_o[p] = 1'b1;
      end else if (v_i[1] && want[1] == 1'(p)) begin
        v_o[p]    = 1'b1;
        dest_o[p] = dest_i[1];
        src_o[p]  = src_i[1];
        data_o[p] = data_i[1];
      end
    end
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 3,
  parameter int DW    = 16,
  parameter int STAGE = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        v_i,
  input  logic [N-1:0][AW-1:0] dest_i,
  input  logic [N-1:0][AW-1:0] src_i,
  input  logic [N-1:0][DW-1:0] data_i,
  input  logic [N-1:0]        mask_i,
  output logic [N-1:0]        v_o,
  output logic [N-1:0][AW-1:0] dest_o,
  output logic [N-1:0][AW-1:0] src_o,
  output logic [N-1:0][DW-1:0] data_o,
  output logic [N-1:0]        mask_o
);
  localparam int SEL_BIT = AW - 1 - STAGE;
  localparam int NSW     = N / 2;

  logic [N-1:0]         sh_v,    nx_v;
  logic [N-1:0][AW-1:0] sh_dest, nx_dest;
  logic [N-1:0][AW-1:0] sh_src,  nx_src;
  logic [N-1:0][DW-1:0] sh_data, nx_data;
  logic [N-1:0]         mask_nx;
  logic [NSW-1:0]       lose;

  always_comb begin
    sh_v    = '0;
    sh_dest = '0;
    sh_src  = '0;
    sh_data = '0;
    for (int j = 0; j < N; j++) begin
      sh_v[shuffle_idx(j, AW)]    = v_i[j];
      sh_dest[shuffle_idx(j, AW)] = dest_i[j];
      sh_src[shuffle_idx(j, AW)]  = src_i[j];
      sh_data[shuffle_idx(j, AW)] = data_i[j];
    end
  end

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    omega_switch #(.AW(AW), .DW(DW), .SEL_BIT(SEL_BIT)) u_sw (
      .v_i    (sh_v[2*k+1:2*k]),
      .dest_i (sh_dest[2*k+1:2*k]),
      .src_i  (sh_src[2*k+1:2*k]),
      .data_i (sh_data[2*k+1:2*k]),
      .v_o    (nx_v[2*k+1:2*k]),
      .dest_o (nx_dest[2*k+1:2*k]),
      .src_o  (nx_src[2*k+1:2*k]),
      .data_o (nx_data[2*k+1:2*k]),
      .lose_o (lose[k])
    );
  end

  // loser is always the lower input of its element
  always_comb begin
    mask_nx = mask_i;
    for (int k = 0; k < NSW; k++) begin
      if (lose[k]) mask_nx[sh_src[2*k+1]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= '0;
      dest_o <= '0;
      src_o  <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else begin
      v_o    <= nx_v;
      dest_o <= nx_dest;
      src_o  <= nx_src;
      data_o <= nx_data;
      mask_o <= mask_nx;
    end
  end

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    localparam logic [AW-1:0] LANE = AW'(j);
    a_r3_lane_matches_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_o[j] |-> (dest_o[j][AW-1 -: STAGE+1] == LANE[STAGE:0]));
  end

  a_r8_word_conservation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ($countones(v_o) + $countones(mask_o)
                   == $past($countones(v_i) + $countones(mask_i))));

  a_r5_block_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ((mask_o & $past(mask_i)) == $past(mask_i)));

  a_r6_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i == '0 && mask_i == '0) |=> (v_o == '0 && mask_o == '0));
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS*$clog2(N_PORTS)-1:0] in_dest_i,
  input  logic [N_PORTS*DATA_W-1:0]   in_data_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_dest_o,
  output logic [N_PORTS*DATA_W-1:0]   out_data_o,
  output logic [N_PORTS-1:0]          blocked_o
);
  localparam int AW         = $clog2(N_PORTS);
  localparam int NUM_STAGES = AW;

  logic [N_PORTS-1:0]             v_c    [NUM_STAGES+1];
  logic [N_PORTS-1:0][AW-1:0]     dest_c [NUM_STAGES+1];
  logic [N_PORTS-1:0][AW-1:0]     src_c  [NUM_STAGES+1];
  logic [N_PORTS-1:0][DATA_W-1:0] data_c [NUM_STAGES+1];
  logic [N_PORTS-1:0]             mask_c [NUM_STAGES+1];

  assign v_c[0]    = in_valid_i;
  assign mask_c[0] = '0;
  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    assign dest_c[0][i] = in_dest_i[i*AW +: AW];
    assign src_c[0][i]  = AW'(i);
    assign data_c[0][i] = in_data_i[i*DATA_W +: DATA_W];
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    omega_stage #(.N(N_PORTS), .AW(AW), .DW(DATA_W), .STAGE(s)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .v_i    (v_c[s]),
      .dest_i (dest_c[s]),
      .src_i  (src_c[s]),
      .data_i (data_c[s]),
      .mask_i (mask_c[s]),
      .v_o    (v_c[s+1]),
      .dest_o (dest_c[s+1]),
      .src_o  (src_c[s+1]),
      .data_o (data_c[s+1]),
      .mask_o (mask_c[s+1])
    );
  end

  assign out_valid_o = v_c[NUM_STAGES];
  assign blocked_o   = mask_c[NUM_STAGES];
  for (genvar i = 0; i < N_PORTS; i++) begin : g_out
    assign out_dest_o[i*AW +: AW]         = dest_c[NUM_STAGES][i];
    assign out_data_o[i*DATA_W +: DATA_W] = data_c[NUM_STAGES][i];
  end
endmodule

// File: tb/omega_fabric_test.sv
module omega_fabric_test;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NV = 10;

  // per vector: valid mask, dest per input, expected source per output (-1 none), expected blocked
  localparam logic [7:0] VM [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11,
                                     8'h0A, 8'h0C, 8'h00, 8'h20, 8'h10};
  localparam int DST [NV][8] = '{
    '{0,1,2,3,4,5,6,7},
    '{0,0,0,0,0,0,0,0},
    '{7,6,5,4,3,2,1,0},
    '{1,2,3,4,5,6,7,0},
    '{5,0,0,0,5,0,0,0},
    '{0,6,0,7,0,0,0,0},
    '{0,0,4,4,0,0,0,0},
    '{3,3,3,3,3,3,3,3},
    '{0,0,0,0,0,2,0,0},
    '{6,6,6,6,6,6,6,6}};
  localparam int ESRC [NV][8] = '{
    '{0,1,2,3,4,5,6,7},
    '{0,-1,-1,-1,-1,-1,-1,-1},
    '{7,6,5,4,3,2,1,0},
    '{7,0,1,2,3,4,5,6},
    '{-1,-1,-1,-1,-1,0,-1,-1},
    '{-1,-1,-1,-1,-1,-1,1,-1},
    '{-1,-1,-1,-1,2,-1,-1,-1},
    '{-1,-1,-1,-1,-1,-1,-1,-1},
    '{-1,-1,5,-1,-1,-1,-1,-1},
    '{-1,-1,-1,-1,-1,-1,4,-1}};
  localparam logic [7:0] EB [NV] = '{8'h00, 8'hFE, 8'h00, 8'h00, 8'h10,
                                     8'h08, 8'h08, 8'h00, 8'h00, 8'h00};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]    in_valid_i = '0;
  logic [N*AW-1:0] in_dest_i = '0;
  logic [N*DW-1:0] in_data_i = '0;
  logic [N-1:0]    out_valid_o;
  logic [N*AW-1:0] out_dest_o;
  logic [N*DW-1:0] out_data_o;
  logic [N-1:0]    blocked_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  omega_fabric #(.N_PORTS(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_dest_i(in_dest_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_dest_o(out_dest_o), .out_data_o(out_data_o),
    .blocked_o(blocked_o));

  function automatic logic [DW-1:0] pay(input int v, input int i);
    return {8'(v), 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_vec(input int v);
    in_valid_i = VM[v];
    for (int i = 0; i < N; i++) begin
      in_dest_i[i*AW +: AW] = AW'(DST[v][i]);
      in_data_i[i*DW +: DW] = pay(v, i);
    end
  endtask

  task automatic drive_idle();
    in_valid_i = '0;
    in_dest_i  = '0;
    in_data_i  = '0;
  endtask

  task automatic check_vec(input int v, input string req);
    logic [N-1:0] ev;
    for (int p = 0; p < N; p++) ev[p] = (ESRC[v][p] >= 0);
    chk(out_valid_o == ev, req, $sformatf("vec%0d out_valid", v), out_valid_o, ev);
    for (int p = 0; p < N; p++) begin
      if (ev[p] && out_valid_o[p]) begin
        chk(out_data_o[p*DW +: DW] == pay(v, ESRC[v][p]), req,
            $sformatf("vec%0d data port%0d", v, p), out_data_o[p*DW +: DW], pay(v, ESRC[v][p]));
        chk(out_dest_o[p*AW +: AW] == AW'(p), req,
            $sformatf("vec%0d dest port%0d", v, p), out_dest_o[p*AW +: AW], p);
      end
    end
    // R5 blocked alignment
    chk(blocked_o == EB[v], {req, " R5"}, $sformatf("vec%0d blocked", v), blocked_o, EB[v]);
    // R8 conservation
    chk($countones(out_valid_o) + $countones(blocked_o) == $countones(VM[v]), "R8",
        $sformatf("vec%0d delivered+blocked", v),
        $countones(out_valid_o) + $countones(blocked_o), $countones(VM[v]));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    // R1: outputs stay clear under reset with busy inputs
    drive_vec(0);
    repeat (3) @(negedge clk);
    chk(out_valid_o == '0, "R1", "valid in reset", out_valid_o, 0);
    chk(blocked_o == '0, "R1", "blocked in reset", blocked_o, 0);
    drive_idle();
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == '0, "R1", "valid after reset", out_valid_o, 0);
    chk(blocked_o == '0, "R1", "blocked after reset", blocked_o, 0);

    // table walk: R3 routing, R4 conflicts, R6 invalid inputs
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive_vec(v);
      @(negedge clk);
      drive_idle();
      @(negedge clk);
      @(negedge clk);
      check_vec(v, (v inside {1, 4, 5, 6}) ? "R4" : (v inside {7, 9}) ? "R6" : "R3");
    end

    // R2: latency of log2(N) registered stages
    @(negedge clk);
    drive_vec(3);
    @(negedge clk);
    drive_idle();
    chk(out_valid_o == '0, "R2", "one edge after drive", out_valid_o, 0);
    @(negedge clk);
    chk(out_valid_o == '0, "R2", "two edges after drive", out_valid_o, 0);
    @(negedge clk);
    check_vec(3, "R2");
    @(negedge clk);
    chk(out_valid_o == '0, "R2", "wave gone next cycle", out_valid_o, 0);

    // R7: back-to-back waves
    @(negedge clk);
    drive_vec(0);
    @(negedge clk);
    drive_vec(1);
    @(negedge clk);
    drive_vec(2);
    @(negedge clk);
    drive_idle();
    check_vec(0, "R7");
    @(negedge clk);
    check_vec(1, "R7");
    @(negedge clk);
    check_vec(2, "R7");

    // R1: mid-run reset clears in-flight wave
    @(negedge clk);
    drive_vec(1);
    @(negedge clk);
    drive_idle();
    rst_ni = 1'b0;
    @(negedge clk);
    chk(out_valid_o == '0, "R1", "valid after mid reset", out_valid_o, 0);
    chk(blocked_o == '0, "R1", "blocked after mid reset", blocked_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid_o == '0, "R1", "no stale wave", out_valid_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule